// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. The integrator, the reference and the zero-crossing comparator sit outside the block. The block drives three analog switch selects: integrator clear, unknown input and opposite-polarity reference. It times both integration phases with a single counter and reports the length of the second phase as the conversion result.

A conversion starts with a clear phase of fixed length. During this phase the integrator is shorted and the counter is nulled. A run-up phase follows, in which the unknown input is integrated for exactly `RUNUP_CYCLES` clocks. This run-up length is chosen as a whole number of interference periods, so that series-mode hum averages out. In the run-down phase the reference is applied and the clocks are counted until the comparator reports that the integrator has returned to zero. The ratio of run-down count to run-up count equals the ratio of the input to the reference. The result therefore does not depend on the RC constant or on the clock frequency.

The comparator passes through a flip-flop synchronizer before the controller uses it. The delay this adds is removed from the reported count. A run-down that lasts longer than twice the run-up ends the conversion with an overrange flag.

Top module: `dsadc_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `overrange_o`, all three switch selects and `result_o` are all 0.
- R2: A `start_i` pulse seen while idle raises `busy_o` and holds `int_rst_o` high for exactly `NULL_CYCLES` clocks, with the input and reference selects low.
- R3: Directly after the clear phase, `sel_in_o` is high for exactly `RUNUP_CYCLES` consecutive clocks.
- R4: `sel_ref_o` goes high in the clock after run-up ends and stays high until the conversion finishes. At no time is more than one of the three selects high.
- R5: If the comparator input falls after k clocked edges with `sel_ref_o` high, the result is k. The synchronizer delay of `SYNC_STAGES` cycles is removed.
- R6: If the comparator is already low when run-down begins (zero input), the result is 0 rather than a wrapped value.
- R7: If k would exceed 2·`RUNUP_CYCLES`, the conversion ends with `overrange_o` = 1 and `result_o` = 2·`RUNUP_CYCLES`. If k equals exactly 2·`RUNUP_CYCLES`, the conversion is a normal result with `overrange_o` = 0.
- R8: `done_o` is high for exactly one cycle per conversion, and `busy_o` is low in that cycle. `result_o` and `overrange_o` change only in a `done_o` cycle and hold between them.
- R9: A `start_i` pulse while `busy_o` is high is ignored: the running conversion is neither restarted nor lengthened, and it produces one result only.
- R10: A `start_i` pulse in the same cycle as `done_o` is accepted and begins a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Asynchronous comparator: 1 while the integrator holds charge above zero |
| sel_in_o | output | 1 | Connect unknown input to the integrator |
| sel_ref_o | output | 1 | Connect opposite-polarity reference to the integrator |
| int_rst_o | output | 1 | Short the integrator capacitor |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| overrange_o | output | 1 | Last conversion exceeded the run-down limit |
| result_o | output | CNT_W | Run-down count of the last conversion |

## Verification
Two events can decide the end of run-down in the same cycle: the comparator trip seen through the synchronizer, and the run-down timeout. Driving an input of exactly twice the reference makes the trip land on the last allowed count, so both conditions hold on one edge. That case is judged correct only if it gives a plain result of 2·`RUNUP_CYCLES` with no overrange flag, while an input slightly larger must set the flag. A second coincidence, a new start arriving in the `done_o` cycle, is provoked by the driver reacting to `done_o`. The bench expects a new conversion with correct clear and run-up lengths.

// File: rtl/dsadc_pkg.sv
// Shared types for the dual-slope converter sequencer.
package dsadc_pkg;
    // Conversion phases in order of use.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_RUNUP = 2'd2,
        PH_RDOWN = 2'd3
    } phase_t;
endpackage

// File: rtl/dsadc_sync.sv
// Multi-stage synchronizer for the asynchronous comparator input.
// Assumes: STAGES >= 2; output delay is exactly STAGES clocks; resets low.
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        genvar g;
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the comparator one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b0;
                end else if (g == 0) begin
                    chain_q[g] <= async_i;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_fsm.sv
// Phase sequencer with one shared counter for clear, run-up and run-down.
// Assumes: cmp_s_i is already synchronized; RUNUP_CYCLES > SYNC_STAGES so
// the synchronizer has settled before run-down; NULL_CYCLES >= 1.
// Emits fin_o on the edge that ends run-down, with the raw count on cnt_o.
module dsadc_fsm
    import dsadc_pkg::*;
#(
    parameter int RUNUP_CYCLES = 2000000,
    parameter int NULL_CYCLES  = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int CNT_W        = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_s_i,
    output logic             busy_o,
    output logic             sel_in_o,
    output logic             sel_ref_o,
    output logic             int_rst_o,
    output logic             fin_o,
    output logic             fin_ovr_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CLEAR_LAST = CNT_W'(NULL_CYCLES - 1);
    localparam logic [CNT_W-1:0] RUNUP_LAST = CNT_W'(RUNUP_CYCLES - 1);
    localparam logic [CNT_W-1:0] RDOWN_LIM  = CNT_W'(2*RUNUP_CYCLES + SYNC_STAGES);

    phase_t           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             trip;
    logic             tmo;

    // Decide the end of run-down: a trip wins over a timeout on the same edge.
    always_comb begin
        trip = (ph_q == PH_RDOWN) && !cmp_s_i;
        tmo  = (ph_q == PH_RDOWN) && cmp_s_i && (cnt_q == RDOWN_LIM);
    end

    // Advance the phase and the shared counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (start_i) begin
                        ph_q  <= PH_CLEAR;
                        cnt_q <= '0;
                    end
                end
                PH_CLEAR: begin
                    if (cnt_q == CLEAR_LAST) begin
                        ph_q  <= PH_RUNUP;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_RUNUP: begin
                    if (cnt_q == RUNUP_LAST) begin
                        ph_q  <= PH_RDOWN;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_RDOWN: begin
                    if (trip || tmo) begin
                        ph_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Switch selects and status are plain decodes of the phase register.
    assign busy_o    = (ph_q != PH_IDLE);
    assign int_rst_o = (ph_q == PH_CLEAR);
    assign sel_in_o  = (ph_q == PH_RUNUP);
    assign sel_ref_o = (ph_q == PH_RDOWN);
    assign fin_o     = trip || tmo;
    assign fin_ovr_o = tmo;
    assign cnt_o     = cnt_q;

    // R4: the integrator never sees two sources at once.
    p_sel_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_in_o, sel_ref_o, int_rst_o}));

    // R2/R3: run-up is always entered straight from the clear phase.
    p_clear_before_runup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_in_o) |-> $past(int_rst_o));

    // R4: run-down is always entered straight from run-up.
    p_ref_after_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_ref_o) |-> $past(sel_in_o));

    // R9: a start past the clear phase never sends the sequence back.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !int_rst_o && start_i) |=> !int_rst_o);

    // R7: run-down never counts beyond its limit.
    p_rdown_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ref_o |-> (cnt_q <= RDOWN_LIM));
endmodule

// File: rtl/dsadc_result.sv
// Result register: removes the synchronizer delay, saturates at zero,
// substitutes the limit value on overrange, and pulses done.
// Assumes: fin_i is a single-cycle strobe from the sequencer.
module dsadc_result #(
    parameter int RUNUP_CYCLES = 2000000,
    parameter int SYNC_STAGES  = 2,
    parameter int CNT_W        = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fin_i,
    input  logic             ovr_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] result_o,
    output logic             ovr_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] LAT     = CNT_W'(SYNC_STAGES);
    localparam logic [CNT_W-1:0] OVR_VAL = CNT_W'(2*RUNUP_CYCLES);

    logic [CNT_W-1:0] corrected;

    // Remove the synchronizer delay without wrapping below zero.
    always_comb begin
        if (ovr_i) begin
            corrected = OVR_VAL;
        end else if (cnt_i < LAT) begin
            corrected = '0;
        end else begin
            corrected = cnt_i - LAT;
        end
    end

    // Capture the result on the finishing edge and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            ovr_o    <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= fin_i;
            if (fin_i) begin
                result_o <= corrected;
                ovr_o    <= ovr_i;
            end
        end
    end

    // R8: done is a single-cycle pulse.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: the result holds between done pulses.
    p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(ovr_o)));

    // R7: an overrange result always carries the limit value.
    p_ovr_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovr_o) |-> (result_o == OVR_VAL));
endmodule

// File: rtl/dsadc_seq.sv
// Top of the dual-slope converter sequencer: comparator synchronizer,
// phase sequencer and result register.
// Assumes: the external integrator ramps up while sel_in_o is high and down
// while sel_ref_o is high, and cmp_i is 1 while its output is above zero.
module dsadc_seq #(
    parameter int RUNUP_CYCLES = 2000000,
    parameter int NULL_CYCLES  = 8,
    parameter int SYNC_STAGES  = 2,
    localparam int CNT_W = $clog2(2*RUNUP_CYCLES + SYNC_STAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic             sel_in_o,
    output logic             sel_ref_o,
    output logic             int_rst_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             overrange_o,
    output logic [CNT_W-1:0] result_o
);
    logic             cmp_s;
    logic             fin;
    logic             fin_ovr;
    logic [CNT_W-1:0] cnt;

    dsadc_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_i),
        .sync_o  (cmp_s)
    );

    dsadc_fsm #(
        .RUNUP_CYCLES (RUNUP_CYCLES),
        .NULL_CYCLES  (NULL_CYCLES),
        .SYNC_STAGES  (SYNC_STAGES),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cmp_s_i   (cmp_s),
        .busy_o    (busy_o),
        .sel_in_o  (sel_in_o),
        .sel_ref_o (sel_ref_o),
        .int_rst_o (int_rst_o),
        .fin_o     (fin),
        .fin_ovr_o (fin_ovr),
        .cnt_o     (cnt)
    );

    dsadc_result #(
        .RUNUP_CYCLES (RUNUP_CYCLES),
        .SYNC_STAGES  (SYNC_STAGES),
        .CNT_W        (CNT_W)
    ) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .fin_i    (fin),
        .ovr_i    (fin_ovr),
        .cnt_i    (cnt),
        .result_o (result_o),
        .ovr_o    (overrange_o),
        .done_o   (done_o)
    );

    // R8: done never coincides with an active conversion.
    p_done_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: tb/sim_dsadc_seq.sv
// Scoreboard bench: a behavioural integer integrator closes the loop.
module sim_dsadc_seq;
    localparam int N1    = 100;
    localparam int NCLR  = 4;
    localparam int SYNC  = 2;
    localparam int CNT_W = $clog2(2*N1 + SYNC + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             cmp_i;
    logic             sel_in_o, sel_ref_o, int_rst_o, busy_o, done_o, overrange_o;
    logic [CNT_W-1:0] result_o;

    int errors = 0;
    int checks = 0;
    int vx = 0;
    int vr = 10;
    int acc = 0;
    int exp_res_q[$];
    bit exp_ovr_q[$];
    int done_seen = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dsadc_seq #(
        .RUNUP_CYCLES (N1),
        .NULL_CYCLES  (NCLR),
        .SYNC_STAGES  (SYNC)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .cmp_i (cmp_i),
        .sel_in_o (sel_in_o), .sel_ref_o (sel_ref_o), .int_rst_o (int_rst_o),
        .busy_o (busy_o), .done_o (done_o), .overrange_o (overrange_o),
        .result_o (result_o)
    );

    // Behavioural integrator and comparator.
    always @(posedge clk) begin
        if (int_rst_o)      acc <= 0;
        else if (sel_in_o)  acc <= acc + vx;
        else if (sel_ref_o) acc <= acc - vr;
    end
    assign cmp_i = (acc > 0);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: queue the expected result and pulse start.
    task automatic convert(input int x, input int r);
        int k;
        vx = x;
        vr = r;
        k = (x == 0) ? 0 : (N1*x + r - 1) / r;
        if (k > 2*N1) begin
            exp_res_q.push_back(2*N1);
            exp_ovr_q.push_back(1'b1);
        end else begin
            exp_res_q.push_back(k);
            exp_ovr_q.push_back(1'b0);
        end
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int n = done_seen;
        while (done_seen == n) @(negedge clk);
    endtask

    // Monitor: compare each result against the scoreboard and check phase lengths.
    int clr_len = 0, in_len = 0;
    bit prev_done = 0, prev_clr = 0, prev_in = 0;
    int prev_res = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_done) begin
                check(!done_o, "R8 done single cycle", done_o, 0);
                check(result_o == CNT_W'(prev_res), "R8 result held", result_o, prev_res);
            end
            if (done_o) begin
                done_seen++;
                check(!busy_o, "R8 busy low at done", busy_o, 0);
                if (exp_res_q.size() == 0) begin
                    check(1'b0, "R9 unexpected result", result_o, -1);
                end else begin
                    int er; bit eo;
                    er = exp_res_q.pop_front();
                    eo = exp_ovr_q.pop_front();
                    check(result_o == CNT_W'(er), "R5/R6/R7 result", result_o, er);
                    check(overrange_o == eo, "R7 overrange flag", overrange_o, eo);
                end
            end
            if (int_rst_o) begin
                clr_len++;
                check(busy_o && !sel_in_o && !sel_ref_o, "R2 clear phase outputs", busy_o, 1);
            end else if (prev_clr) begin
                check(clr_len == NCLR, "R2 clear length", clr_len, NCLR);
                check(sel_in_o, "R3 run-up follows clear", sel_in_o, 1);
                clr_len = 0;
            end
            if (sel_in_o) in_len++;
            else if (prev_in) begin
                check(in_len == N1, "R3 run-up length", in_len, N1);
                check(sel_ref_o, "R4 run-down follows run-up", sel_ref_o, 1);
                in_len = 0;
            end
            if ((sel_in_o + sel_ref_o + int_rst_o) > 1)
                check(1'b0, "R4 selects exclusive", sel_in_o + sel_ref_o + int_rst_o, 1);
        end
        prev_done = done_o;
        prev_clr  = int_rst_o;
        prev_in   = sel_in_o;
        prev_res  = int'(result_o);
    end

    // Watchdog.
    initial begin
        wait (cyc > 60000);
        check(1'b0, "watchdog", cyc, 60000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(!busy_o && !done_o && !overrange_o && !sel_in_o && !sel_ref_o && !int_rst_o,
              "R1 reset outputs", busy_o, 0);
        check(result_o == '0, "R1 reset result", result_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        convert(10, 10);  wait_done();   // R5 k = 100
        convert(7, 10);   wait_done();   // R5 k = 70
        convert(3, 7);    wait_done();   // R5 ceil(300/7) = 43
        convert(1, 100);  wait_done();   // R5 k = 1
        convert(0, 10);   wait_done();   // R6 zero input
        convert(20, 10);  wait_done();   // R7 k = 200 exactly, trip and timeout coincide
        convert(21, 10);  wait_done();   // R7 overrange

        // R9: start during run-up is ignored.
        convert(13, 10);
        while (!sel_in_o) @(negedge clk);
        repeat (10) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!int_rst_o && sel_in_o, "R9 start in run-up ignored", int_rst_o, 0);
        while (!sel_ref_o) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(sel_ref_o, "R9 start in run-down ignored", sel_ref_o, 1);
        wait_done();
        repeat (5) @(negedge clk);
        check(!busy_o && exp_res_q.size() == 0, "R9 single result", busy_o, 0);

        // R10: start in the done cycle.
        convert(5, 10);
        while (!done_o) @(negedge clk);
        convert(15, 10);
        check(int_rst_o && busy_o, "R10 start at done accepted", int_rst_o, 1);
        wait_done();
        repeat (3) @(negedge clk);
        check(exp_res_q.size() == 0, "R10 all results seen", exp_res_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule